// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character from a host into an asynchronous serial frame on a single output line. A mode byte, supplied by a neighbouring control block, sets the frame layout. That layout covers the character length, whether a parity bit is sent and its sense, the number of stop bits, and how many clock cycles each bit lasts. The host writes one character into a single holding register. The character moves into the frame shifter as soon as the line is free and transmission is allowed.

Two status outputs guide the host. `tx_ready` says the holding register can take another character. `tx_empty` says nothing is waiting and no frame is on the line. Two command inputs shape the line. One enable input gates whether new frames may start. A break input forces the line low for as long as it is held. The mode byte is sampled at the edge where a frame starts, so it may change freely between frames.

Top module: `async_frame_tx`

## Requirements
- R1: While and after reset, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1 until a character is written.
- R2: A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then high stop bits. The line idles high. A character written into an idle, enabled block shows its start bit on `txd` from the second rising edge after the write strobe is sampled.
- R3: Mode bits [3:2] set the character length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits). Bits of `wr_data` above that length are never sent.
- R4: Mode bit 4 = 1 adds a parity bit after the data. Mode bit 5 = 1 makes the count of ones over data and parity even; 0 makes it odd. Bit 5 has no effect when bit 4 is 0.
- R5: Mode bits [7:6] set the stop time: 01 = one bit time, 10 = one and a half bit times (two cycles when a bit lasts one cycle), 11 = two bit times.
- R6: Mode bits [1:0] set the cycles per bit: 01 = 1, 10 = DIV_MID (16), 11 = DIV_HI (64). The mode byte is captured when a frame starts.
- R7: A write strobe while `tx_ready` is 0 is ignored, and the character already held is the one sent.
- R8: While `tx_en` is 0, no new frame starts and the held character stays held. A frame already on the line runs to its end.
- R9: While `send_break` is 1, `txd` is 0 from the next cycle on, and no new frame starts. The line returns to its normal value the cycle after `send_break` falls.
- R10: `tx_ready` is 1 exactly when the holding register is empty. `tx_empty` is 1 exactly when it is empty and no frame is on the line. A held character starts right after the last stop cycle, with no idle cycle between frames.
- R11: Mode code 00 in bits [1:0] is treated as one cycle per bit. Code 00 in bits [7:6] is treated as one stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_byte | input | 8 | Packed frame layout: stop [7:6], parity sense [5], parity enable [4], length [3:2], rate [1:0] |
| tx_en | input | 1 | Allows new frames to start |
| send_break | input | 1 | Forces the line low and holds off new frames |
| wr_stb | input | 1 | One-cycle write strobe for `wr_data` |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial output line |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing held and no frame in progress |

## Verification
The bench targets the back-to-back start after the final stop cycle; a design that inserts an idle cycle there shifts every following bit by one cycle. It covers the one-and-a-half stop setting at both 16 and 1 cycles per bit; a design that truncates the half bit ends the frame early, or it leaves a one-cycle stop at the 1x rate. It writes twice into a full holding register and drops the enable in the middle of a frame. A design that lets the second write overwrite the first sends the wrong character, and one that aborts the frame on disable cuts off its tail. It also tests parity with odd and even data weights, short characters with high bits set in the data, and a break held across a pending character. A wrong parity sense flips a single bit, stray high bits appear on the line, and a frame that starts under break appears too early once the break ends.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_MID = 2'd1,
    RATE_HI  = 2'd2
  } rate_e;

  typedef enum logic [1:0] {
    STOP_ONE  = 2'd0,
    STOP_HALF = 2'd1,
    STOP_TWO  = 2'd2
  } stop_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [3:0] char_len;
    logic       par_en;
    logic       par_even;
    stop_e      stop;
    rate_e      rate;
  } frame_fmt_t;

endpackage

// File: rtl/aftx_mode_decode.sv
module aftx_mode_decode
  import aftx_pkg::*;
(
  input  logic [7:0] mode_byte,
  output frame_fmt_t fmt
);

  always_comb begin
    fmt.char_len = 4'd5 + {2'b00, mode_byte[3:2]};
    fmt.par_en   = mode_byte[4];
    // sense only matters with parity on
    fmt.par_even = mode_byte[5] & mode_byte[4];

    case (mode_byte[7:6])
      2'b10:   fmt.stop = STOP_HALF;
      2'b11:   fmt.stop = STOP_TWO;
      default: fmt.stop = STOP_ONE;   // 00 falls back to one stop (R11)
    endcase

    case (mode_byte[1:0])
      2'b10:   fmt.rate = RATE_MID;
      2'b11:   fmt.rate = RATE_HI;
      default: fmt.rate = RATE_X1;    // 00 falls back to 1x (R11)
    endcase
  end

endmodule

// File: rtl/aftx_bit_timing.sv
module aftx_bit_timing
  import aftx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  parameter int CNT_W   = 8
) (
  input  frame_fmt_t       fmt,
  output logic [CNT_W-1:0] bit_cyc,
  output logic [CNT_W-1:0] stop_cyc
);

  localparam logic [CNT_W-1:0] CYC_X1  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CYC_MID = CNT_W'(DIV_MID);
  localparam logic [CNT_W-1:0] CYC_HI  = CNT_W'(DIV_HI);

  always_comb begin
    case (fmt.rate)
      RATE_MID: bit_cyc = CYC_MID;
      RATE_HI:  bit_cyc = CYC_HI;
      default:  bit_cyc = CYC_X1;
    endcase
  end

  always_comb begin
    case (fmt.stop)
      STOP_TWO:  stop_cyc = bit_cyc + bit_cyc;
      // half a cycle cannot be counted at 1x, so it rounds up to two
      STOP_HALF: stop_cyc = (bit_cyc == CYC_X1) ? CNT_W'(2)
                                                : bit_cyc + (bit_cyc >> 1);
      default:   stop_cyc = bit_cyc;
    endcase
  end

endmodule

// File: rtl/aftx_hold_buf.sv
module aftx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (take) begin
      hold_valid <= 1'b0;
    end else if (wr_stb && !hold_valid) begin
      // writes into a full register are dropped (R7)
      hold_valid <= 1'b1;
      hold_data  <= wr_data;
    end
  end

endmodule

// File: rtl/aftx_frame_shift.sv
module aftx_frame_shift
  import aftx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] ld_data,
  input  frame_fmt_t        ld_fmt,
  input  logic [CNT_W-1:0]  bit_cyc,
  input  logic [CNT_W-1:0]  stop_cyc,
  output logic              line,
  output logic              idle,
  output logic              last_cycle
);

  tx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [3:0]        bits_left;
  logic              par_acc;
  logic              par_en_q;
  logic [CNT_W-1:0]  bit_q;
  logic [CNT_W-1:0]  stop_q;

  assign idle       = (state == ST_IDLE);
  assign last_cycle = (state == ST_STOP) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      bits_left <= '0;
      par_acc   <= 1'b0;
      par_en_q  <= 1'b0;
      bit_q     <= '0;
      stop_q    <= '0;
      line      <= 1'b1;
    end else if (start) begin
      state     <= ST_START;
      cnt       <= bit_cyc - CNT_W'(1);
      shreg     <= ld_data;
      bits_left <= ld_fmt.char_len;
      par_acc   <= ~ld_fmt.par_even;
      par_en_q  <= ld_fmt.par_en;
      bit_q     <= bit_cyc;
      stop_q    <= stop_cyc;
      line      <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else begin
        case (state)
          ST_START, ST_DATA: begin
            if (bits_left != 4'd0) begin
              state     <= ST_DATA;
              line      <= shreg[0];
              par_acc   <= par_acc ^ shreg[0];
              shreg     <= {1'b0, shreg[DATA_W-1:1]};
              bits_left <= bits_left - 4'd1;
              cnt       <= bit_q - CNT_W'(1);
            end else if (par_en_q) begin
              state <= ST_PAR;
              line  <= par_acc;
              cnt   <= bit_q - CNT_W'(1);
            end else begin
              state <= ST_STOP;
              line  <= 1'b1;
              cnt   <= stop_q - CNT_W'(1);
            end
          end
          ST_PAR: begin
            state <= ST_STOP;
            line  <= 1'b1;
            cnt   <= stop_q - CNT_W'(1);
          end
          default: begin
            state <= ST_IDLE;
            line  <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import aftx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        mode_byte,
  input  logic              tx_en,
  input  logic              send_break,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);

  localparam int CNT_W = $clog2(2 * DIV_HI + 1);

  frame_fmt_t        fmt;
  logic [CNT_W-1:0]  bit_cyc;
  logic [CNT_W-1:0]  stop_cyc;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              sh_line;
  logic              sh_idle;
  logic              sh_last;
  logic              brk_q;

  aftx_mode_decode u_decode (
    .mode_byte (mode_byte),
    .fmt       (fmt)
  );

  aftx_bit_timing #(
    .DIV_MID (DIV_MID),
    .DIV_HI  (DIV_HI),
    .CNT_W   (CNT_W)
  ) u_timing (
    .fmt      (fmt),
    .bit_cyc  (bit_cyc),
    .stop_cyc (stop_cyc)
  );

  aftx_hold_buf #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .take       (load),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  // a new frame may follow the final stop cycle directly
  assign load = hold_valid && tx_en && !send_break && (sh_idle || sh_last);

  aftx_frame_shift #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .start      (load),
    .ld_data    (hold_data),
    .ld_fmt     (fmt),
    .bit_cyc    (bit_cyc),
    .stop_cyc   (stop_cyc),
    .line       (sh_line),
    .idle       (sh_idle),
    .last_cycle (sh_last)
  );

  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= send_break;
  end

  assign txd      = sh_line & ~brk_q;
  assign tx_ready = ~hold_valid;
  assign tx_empty = ~hold_valid & sh_idle;

endmodule

// File: rtl/aftx_checker.sv
module aftx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic send_break,
  input logic wr_stb,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty
);

  // R10: empty implies the holding register is free
  a_r10_empty_has_room: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready);

  // R10: only a write can take the holding register from free to full
  a_r10_ready_needs_write: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && !wr_stb) |=> tx_ready);

  // R9: an active break pulls the line low on the following cycle
  a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
    send_break |=> !txd);

  // R8: a held character stays held while transmission is disabled
  a_r8_disabled_holds: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !tx_ready) |=> !tx_ready);

  // R2: an empty block with no break keeps the line high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !send_break) |=> txd);

endmodule

bind async_frame_tx aftx_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_en      (tx_en),
  .send_break (send_break),
  .wr_stb     (wr_stb),
  .txd        (txd),
  .tx_ready   (tx_ready),
  .tx_empty   (tx_empty)
);

// File: tb/async_frame_tx_tb.sv
module async_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mode_byte = 8'h4D;
  logic       tx_en = 1'b1;
  logic       send_break = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, tx_ready, tx_empty;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural model state
  bit   m_q[$];        // line value per cycle, front = current cycle
  bit   m_hv = 1'b0;
  logic [7:0] m_hd = 8'h00;
  bit   m_brk = 1'b0;
  bit   hv_pre;

  always #4 clk = ~clk;

  async_frame_tx u_dut (
    .clk        (clk),
    .rst        (rst),
    .mode_byte  (mode_byte),
    .tx_en      (tx_en),
    .send_break (send_break),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty)
  );

  function automatic void build_frame(logic [7:0] m, logic [7:0] d);
    int per, len, stop_n;
    bit p;
    per = (m[1:0] == 2'b10) ? 16 : (m[1:0] == 2'b11) ? 64 : 1;
    len = 5 + int'(m[3:2]);
    repeat (per) m_q.push_back(1'b0);
    p = 1'b0;
    for (int i = 0; i < len; i++) begin
      p = p ^ d[i];
      repeat (per) m_q.push_back(d[i]);
    end
    if (m[4]) begin
      if (!m[5]) p = ~p;
      repeat (per) m_q.push_back(p);
    end
    case (m[7:6])
      2'b10:   stop_n = (per == 1) ? 2 : per + per / 2;
      2'b11:   stop_n = 2 * per;
      default: stop_n = per;
    endcase
    repeat (stop_n) m_q.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_hv  = 1'b0;
      m_hd  = 8'h00;
      m_brk = 1'b0;
    end else begin
      hv_pre = m_hv;
      if (m_q.size() > 0) void'(m_q.pop_front());
      if (m_q.size() == 0 && m_hv && tx_en && !send_break) begin
        build_frame(mode_byte, m_hd);
        m_hv = 1'b0;
      end
      if (wr_stb && !hv_pre) begin
        m_hv = 1'b1;
        m_hd = wr_data;
      end
      m_brk = send_break;
    end
  end

  function automatic void check(string what, logic got, logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b",
               cur_req, what, $time, got, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("txd", txd, (m_q.size() > 0 ? m_q[0] : 1'b1) & ~m_brk);
      check("tx_ready", tx_ready, ~m_hv);
      check("tx_empty", tx_empty, ~m_hv & (m_q.size() == 0));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write(logic [7:0] d);
    wr_data = d;
    wr_stb  = 1'b1;
    tick();
    wr_stb  = 1'b0;
  endtask

  task automatic wait_ready();
    while (m_hv) tick();
  endtask

  task automatic wait_idle();
    while (m_hv || m_q.size() != 0) tick();
    tick(2);
  endtask

  task automatic send(logic [7:0] m, logic [7:0] d);
    wait_idle();
    mode_byte = m;
    write(d);
    wait_idle();
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    cur_req = "R1";             // reset state: line high, ready, empty
    tick(5);

    cur_req = "R2";             // 8 bits, no parity, 1 stop, 1x
    send(8'h4D, 8'hA5);
    cur_req = "R3";             // 5 and 6 bit characters, high bits set
    send(8'h41, 8'hFF);
    send(8'h45, 8'hC3);
    cur_req = "R4";             // even parity 7 bits 16x, odd parity 8 bits 1x
    send(8'h7A, 8'h53);
    send(8'h5D, 8'h0F);
    send(8'h5D, 8'h0E);
    send(8'h6D, 8'h0E);         // sense bit set, parity off
    cur_req = "R5";             // one and a half and two stop bits
    send(8'h8E, 8'h3C);
    send(8'h8D, 8'h3C);
    send(8'hCD, 8'h81);
    cur_req = "R6";             // 64 cycles per bit
    send(8'hC7, 8'h2A);

    cur_req = "R7";             // second write into full register is dropped
    wait_idle();
    mode_byte = 8'h4D;
    tx_en = 1'b0;
    write(8'h11);
    write(8'h22);
    tick(3);
    tx_en = 1'b1;
    wait_idle();

    cur_req = "R8";             // disabled: hold, then disable mid-frame
    tx_en = 1'b0;
    write(8'h96);
    tick(20);
    tx_en = 1'b1;
    mode_byte = 8'h4E;
    wait_ready();
    write(8'h5A);
    tick(30);
    tx_en = 1'b0;
    tick(200);
    tx_en = 1'b1;
    wait_idle();

    cur_req = "R9";             // break held over a pending character
    mode_byte = 8'h4D;
    send_break = 1'b1;
    tick(3);
    write(8'h3F);
    tick(40);
    send_break = 1'b0;
    wait_idle();
    write(8'hF0);
    tick(4);
    send_break = 1'b1;          // break in mid-frame
    tick(6);
    send_break = 1'b0;
    wait_idle();

    cur_req = "R10";            // back-to-back frames
    mode_byte = 8'h5E;
    write(8'h81);
    wait_ready();
    write(8'h7E);
    wait_ready();
    mode_byte = 8'hCD;
    write(8'h55);
    wait_idle();

    cur_req = "R11";            // codes 00 for stop and rate
    send(8'h0D, 8'h69);
    send(8'h4C, 8'h96);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL %s watchdog: actual hung expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule